// File: doc/BRIEF.md
# Interrupt Wakeup Generator with Per-CPU Enable Banks

This block sits next to a generic interrupt controller inside an always-on power domain. A vector of shared peripheral interrupt lines passes through it to the downstream controller with no change. Two of these lines come from dedicated external pins that are active-low, and the block inverts them so that every line on the downstream side is active-high. While lines pass through, the block decides whether any of them should wake a CPU. Each CPU has its own bank of 32-bit enable registers with one bit per interrupt. A CPU's wakeup request goes high in the cycle after any active line has its enable bit set for that CPU.

Software reads and writes the enable registers through a simple memory-mapped port. The port has a one-cycle write strobe, and read data appears in the cycle after the read strobe. The number of enable registers per CPU is a parameter. Four registers give 128 interrupts, five give 160 and seven give 224. The number of CPUs is also a parameter.

Top module: `wake_gen_top`

## Requirements
- R1: Interrupt n is controlled by bit (n mod 32) of enable register n>>5 in each CPU's bank.
- R2: The byte address of CPU c's enable register k is c*0x400 + 4*k. Address bits [11:10] select the CPU, bits [9:2] select the register, and bits [1:0] are ignored.
- R3: After reset every enable bit of every CPU is zero, wake_req is zero and rdata is zero.
- R4: irq_out follows irq_in combinationally for every line other than the two dedicated pins, whatever the enable bits hold.
- R5: Lines PIN_A (default 7) and PIN_B (default 119) are active-low at irq_in. They appear inverted on irq_out and are treated as active when irq_in is 0.
- R6: wake_req[c] is a register. After each clock edge it equals the OR, taken over all interrupts, of (line active on irq_out AND CPU c's enable bit), sampled at that edge.
- R7: wake_req is not latched. It drops one cycle after the last enabled line becomes inactive or its enable bit is cleared.
- R8: Writing 0x00000000 to an enable register masks all 32 of its interrupts. Writing 0xFFFFFFFF unmasks all 32.
- R9: An address whose register index is not below NUM_BANKS, or whose CPU field is not below NUM_CPUS, reads as zero. A write to such an address changes no enable bit.
- R10: rdata is loaded on the edge where rd_en is sampled high and holds its value while rd_en stays low. A read and a write in the same cycle return the value the register had before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Raw interrupt lines; two dedicated pins are active-low |
| irq_out | output | NUM_BANKS*32 | Active-high lines to the downstream controller |
| wr_en | input | 1 | One-cycle write strobe |
| rd_en | input | 1 | One-cycle read strobe |
| addr | input | 12 | Byte address of an enable register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| wake_req | output | NUM_CPUS | Per-CPU registered wakeup request |

## Verification
The assertions assume that wr_en and rd_en are the only ways to change the enable state. They also assume that irq_in is stable around each rising edge. The bench meets both assumptions by driving every input on the falling clock edge. It also leaves both strobes low in any cycle where it checks wake_req against the enable model. Random addresses cover the full 12-bit range, including out-of-range register indices, CPU field values 2 and 3, and nonzero low address bits. For that reason the checks for ignored accesses rely only on the decode rules given in R2 and R9.

// File: rtl/wkg_pkg.sv
package wkg_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 12;
  localparam int CPU_SEL_W = 2;
  localparam int IDX_W     = 8;
  localparam int CPU_LSB   = 10;  // 0x400 stride between CPU banks
  localparam int IDX_LSB   = 2;   // 4-byte stride between registers

  typedef struct packed {
    logic                 hit;
    logic [CPU_SEL_W-1:0] cpu;
    logic [IDX_W-1:0]     idx;
  } wkg_dec_t;
endpackage

// File: rtl/wkg_polarity.sv
module wkg_polarity #(
  parameter int NUM_IRQ = 160,
  parameter int PIN_A   = 7,
  parameter int PIN_B   = 119
) (
  input  logic [NUM_IRQ-1:0] raw_lines,
  output logic [NUM_IRQ-1:0] fixed_lines
);
  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    if (i == PIN_A || i == PIN_B) begin : g_inv
      assign fixed_lines[i] = ~raw_lines[i];
    end else begin : g_thru
      assign fixed_lines[i] = raw_lines[i];
    end
  end
endmodule

// File: rtl/wkg_decode.sv
module wkg_decode import wkg_pkg::*; #(
  parameter int NUM_BANKS = 5,
  parameter int NUM_CPUS  = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output wkg_dec_t          dec
);
  always_comb begin
    dec.cpu = addr[CPU_LSB +: CPU_SEL_W];
    dec.idx = addr[IDX_LSB +: IDX_W];
    dec.hit = (int'(dec.cpu) < NUM_CPUS) && (int'(dec.idx) < NUM_BANKS);
  end
endmodule

// File: rtl/wkg_enable_bank.sv
module wkg_enable_bank import wkg_pkg::*; #(
  parameter int NUM_BANKS = 5,
  parameter int CPU_ID    = 0,
  localparam int NUM_IRQ  = NUM_BANKS * REG_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wkg_dec_t           dec,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wdata,
  output logic [NUM_IRQ-1:0] en_bits
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_reg
    logic             load;
    logic [REG_W-1:0] en_d, en_q;

    always_comb begin
      load = wr_en && dec.hit && (dec.cpu == CPU_SEL_W'(CPU_ID)) &&
             (dec.idx == IDX_W'(b));
      en_d = load ? wdata : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
    end

    assign en_bits[b*REG_W +: REG_W] = en_q;
  end
endmodule

// File: rtl/wkg_wake_unit.sv
module wkg_wake_unit #(
  parameter int NUM_IRQ = 160
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] active,
  input  logic [NUM_IRQ-1:0] enable,
  output logic               wake
);
  logic wake_d, wake_q;

  always_comb wake_d = |(active & enable);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  assign wake = wake_q;
endmodule

// File: rtl/wake_gen_top.sv
module wake_gen_top import wkg_pkg::*; #(
  parameter int NUM_BANKS = 5,
  parameter int NUM_CPUS  = 2,
  parameter int PIN_A     = 7,
  parameter int PIN_B     = 119,
  localparam int NUM_IRQ  = NUM_BANKS * REG_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_IRQ-1:0]  irq_in,
  output logic [NUM_IRQ-1:0]  irq_out,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  output logic [NUM_CPUS-1:0] wake_req
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  wkg_polarity #(.NUM_IRQ(NUM_IRQ), .PIN_A(PIN_A), .PIN_B(PIN_B)) u_pol (
    .raw_lines   (irq_in),
    .fixed_lines (irq_out)
  );

  wkg_dec_t dec;
  wkg_decode #(.NUM_BANKS(NUM_BANKS), .NUM_CPUS(NUM_CPUS)) u_dec (
    .addr (addr),
    .dec  (dec)
  );

  logic [NUM_CPUS*NUM_IRQ-1:0] en_flat;

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    wkg_enable_bank #(.NUM_BANKS(NUM_BANKS), .CPU_ID(c)) u_bank (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .dec     (dec),
      .wr_en   (wr_en),
      .wdata   (wdata),
      .en_bits (en_flat[c*NUM_IRQ +: NUM_IRQ])
    );
    wkg_wake_unit #(.NUM_IRQ(NUM_IRQ)) u_wake (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .active (irq_out),
      .enable (en_flat[c*NUM_IRQ +: NUM_IRQ]),
      .wake   (wake_req[c])
    );
  end

  // read path
  logic [REG_W-1:0] rd_word, rdata_d, rdata_q;

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (dec.hit && dec.cpu == CPU_SEL_W'(c) && dec.idx == IDX_W'(b))
          rd_word = en_flat[c*NUM_IRQ + b*REG_W +: REG_W];
      end
    end
    rdata_d = rd_en ? rd_word : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/wkg_checker.sv
module wkg_checker import wkg_pkg::*; #(
  parameter int NUM_BANKS = 5,
  parameter int NUM_CPUS  = 2,
  parameter int PIN_A     = 7,
  parameter int PIN_B     = 119,
  localparam int NUM_IRQ  = NUM_BANKS * REG_W
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_IRQ-1:0]          irq_in,
  input logic [NUM_IRQ-1:0]          irq_out,
  input logic                        wr_en,
  input logic                        rd_en,
  input logic [ADDR_W-1:0]           addr,
  input logic [REG_W-1:0]            rdata,
  input logic [NUM_CPUS-1:0]         wake_req,
  input logic [NUM_CPUS*NUM_IRQ-1:0] en_flat
);
  localparam logic [NUM_IRQ-1:0] INV_MASK =
    (NUM_IRQ'(1) << PIN_A) | (NUM_IRQ'(1) << PIN_B);

  logic bad_addr;
  assign bad_addr = (int'(addr[CPU_LSB +: CPU_SEL_W]) >= NUM_CPUS) ||
                    (int'(addr[IDX_LSB +: IDX_W]) >= NUM_BANKS);

  // R4 and R5: only the two dedicated pins differ between irq_in and irq_out
  assert_passthru_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out ^ irq_in) == INV_MASK);

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_wk
    // R6 and R7: registered, unlatched wakeup
    assert_wake_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> wake_req[c] == $past(|(irq_out & en_flat[c*NUM_IRQ +: NUM_IRQ])));
  end

  assert_bad_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bad_addr) |=> $stable(en_flat));

  assert_bad_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bad_addr) |=> rdata == '0);

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind wake_gen_top wkg_checker #(
  .NUM_BANKS(NUM_BANKS), .NUM_CPUS(NUM_CPUS), .PIN_A(PIN_A), .PIN_B(PIN_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .wake_req(wake_req), .en_flat(en_flat)
);

// File: tb/sim_wake_gen_top.sv
module sim_wake_gen_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 5;
  localparam int NC   = 2;
  localparam int NIRQ = NB * 32;
  localparam int PA   = 7;
  localparam int PB   = 119;
  localparam logic [NIRQ-1:0] INV = (NIRQ'(1) << PA) | (NIRQ'(1) << PB);
  localparam logic [NIRQ-1:0] IDLE = INV;  // dedicated pins high = inactive

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NIRQ-1:0] irq_in = IDLE;
  logic [NIRQ-1:0] irq_out;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [11:0]     addr = '0;
  logic [31:0]     wdata = '0;
  logic [31:0]     rdata;
  logic [NC-1:0]   wake_req;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] m_en [0:3][0:255];

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_gen_top #(.NUM_BANKS(NB), .NUM_CPUS(NC), .PIN_A(PA), .PIN_B(PB)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .wake_req(wake_req)
  );

  task automatic check(input bit ok, input string req,
                       input logic [NIRQ-1:0] act, input logic [NIRQ-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit hit(input logic [11:0] a);
    return (int'(a[11:10]) < NC) && (int'(a[9:2]) < NB);
  endfunction

  function automatic logic [NC-1:0] exp_wake(input logic [NIRQ-1:0] lines);
    logic [NC-1:0] w = '0;
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NIRQ; i++)
        if ((lines[i] ^ INV[i]) && m_en[c][i >> 5][i % 32]) w[c] = 1'b1;
    return w;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
    if (hit(a)) m_en[a[11:10]][a[9:2]] = d;
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    logic [31:0] e;
    e = hit(a) ? m_en[a[11:10]][a[9:2]] : 32'h0;
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0;
    check(rdata === e, req, NIRQ'(rdata), NIRQ'(e));
  endtask

  task automatic drive_irq(input logic [NIRQ-1:0] v, input string req);
    logic [NC-1:0] e;
    @(negedge clk); irq_in = v;
    #1 check(irq_out === (v ^ INV), "R4", irq_out, v ^ INV);
    e = exp_wake(v);
    @(negedge clk);
    check(wake_req === e, req, NIRQ'(wake_req), NIRQ'(e));
  endtask

  function automatic logic [NIRQ-1:0] rnd_lines();
    logic [NIRQ-1:0] v;
    for (int w = 0; w < NB; w++) v[w*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [NIRQ-1:0] v;
    void'($urandom(32'h5EED_0042));
    for (int c = 0; c < 4; c++) for (int b = 0; b < 256; b++) m_en[c][b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R3 reset state
    check(wake_req === '0, "R3", NIRQ'(wake_req), '0);
    check(rdata === '0, "R3", NIRQ'(rdata), '0);
    for (int c = 0; c < NC; c++)
      for (int b = 0; b < NB; b++) rd(12'((c << 10) | (b << 2)), "R3");
    // R8 all ones / all zeros
    wr(12'h000, 32'hFFFF_FFFF); rd(12'h000, "R8");
    drive_irq(IDLE | (NIRQ'(1) << 3), "R8");
    wr(12'h000, 32'h0); rd(12'h000, "R8");
    drive_irq(IDLE | (NIRQ'(1) << 3), "R8");
    // R1 and R2: interrupt 37 on CPU1 -> register 1 at 0x404, bit 5
    wr(12'h404, 32'h0000_0020);
    drive_irq(IDLE | (NIRQ'(1) << 37), "R1");
    check(wake_req === 2'b10, "R2", NIRQ'(wake_req), NIRQ'(2'b10));
    // R7 drop when line goes inactive
    drive_irq(IDLE, "R7");
    check(wake_req === 2'b00, "R7", NIRQ'(wake_req), '0);
    // R7 drop when enable cleared
    drive_irq(IDLE | (NIRQ'(1) << 37), "R6");
    wr(12'h404, 32'h0);
    @(negedge clk);
    check(wake_req === 2'b00, "R7", NIRQ'(wake_req), '0);
    // R5 dedicated pin 7 active-low on CPU0
    wr(12'h000, 32'h0000_0080);
    drive_irq(IDLE & ~(NIRQ'(1) << PA), "R5");
    check(wake_req[0] === 1'b1 && irq_out[PA] === 1'b1, "R5",
          NIRQ'({wake_req[0], irq_out[PA]}), NIRQ'(2'b11));
    drive_irq(IDLE, "R5");
    // R9 unimplemented register and CPU field
    wr(12'h014, 32'hDEAD_BEEF); rd(12'h014, "R9");
    wr(12'h800, 32'hDEAD_BEEF); rd(12'h800, "R9");
    rd(12'h000, "R9");
    // R2 low address bits ignored
    wr(12'h40B, 32'h1234_5678); rd(12'h408, "R2");
    // R10 hold and read-before-write
    rd(12'h408, "R10");
    repeat (3) @(negedge clk);
    check(rdata === 32'h1234_5678, "R10", NIRQ'(rdata), NIRQ'(32'h1234_5678));
    @(negedge clk); rd_en = 1; wr_en = 1; addr = 12'h408; wdata = 32'hAAAA_5555;
    @(negedge clk); rd_en = 0; wr_en = 0; m_en[1][2] = 32'hAAAA_5555;
    check(rdata === 32'h1234_5678, "R10", NIRQ'(rdata), NIRQ'(32'h1234_5678));
    rd(12'h408, "R10");
    // random mix
    for (int n = 0; n < 400; n++) begin
      case ($urandom % 3)
        0: wr(12'($urandom), $urandom);
        1: rd(12'($urandom), "R9");
        default: begin
          v = rnd_lines();
          drive_irq(v, "R6");
        end
      endcase
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule